// File: doc/BRIEF.md
# DMA Page Address Composer

This block builds the 24-bit physical bus address for a system DMA engine with eight request channels. The engine is made of two cascaded controllers with four channels each. Each controller keeps only a 16-bit current address for a channel. The upper address bits come from a bank of eight 8-bit page registers, one per channel. Software writes these registers through a small 16-byte I/O window.

Channels 0 to 3 move bytes. On these channels the page register supplies bits 23:16 and the current address supplies bits 15:0. Channels 4 to 7 move 16-bit words, and their counter holds the physical address divided by two. On these channels the counter is shifted up by one bit. Bit 0 of the result is forced to zero, and the counter's top bit takes the place of page bit 0. Page bit 0 therefore plays no part in the address.

The engine presents the active channel number and that channel's current address. One clock later the block returns the composed address and a flag that marks a word transfer. A transfer may cover at most 64 KiB on a byte channel and 128 KiB on a word channel. On a word channel both the start address and the length must be even.

Top module: `dma_page_composer`

## Requirements
- R1: After a synchronous reset, all eight page registers read as zero, and `bus_addr` and `word_xfer` are zero.
- R2: A write to window offset 0x7, 0x3, 0x1 or 0x2 loads the page register of channel 0, 1, 2 or 3 respectively.
- R3: A write to window offset 0xF, 0xB, 0x9 or 0xA loads the page register of channel 4, 5, 6 or 7 respectively.
- R4: For a selected channel 0 to 3, `bus_addr` equals {page[7:0], chan_addr[15:0]}.
- R5: For a selected channel 4 to 7, `bus_addr` equals {page[7:1], chan_addr[15:0], 1'b0}, so bit 0 of the output is always zero.
- R6: On channels 4 to 7, bit 0 of the page register has no effect on `bus_addr`.
- R7: A write to any of the unused offsets 0x0, 0x4, 0x5, 0x6, 0x8, 0xC, 0xD and 0xE changes no page register.
- R8: `word_xfer` is 1 exactly when the selected channel number is 4 or higher, which is when bit 2 of `chan_sel` is 1.
- R9: Both outputs are registered. They reflect `chan_sel`, `chan_addr` and the page contents as sampled at the previous rising clock edge. A page write therefore first shows on the output at the second edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Page window write strobe |
| wr_off | input | 4 | Byte offset within the page window |
| wr_data | input | 8 | Page value to write |
| chan_sel | input | 3 | Active DMA channel number |
| chan_addr | input | 16 | Current address counter of the active channel |
| bus_addr | output | 24 | Composed physical address, registered |
| word_xfer | output | 1 | High when the active channel is a word channel, registered |

## Verification
The bench builds the block with its default parameters: eight channels, 8-bit pages, 16-bit counters and a 4-bit window offset. With these values the full window of sixteen offsets can be covered, including every unused offset and both halves of the channel map. Random writes to any offset are mixed with random channel and address selections, so stale pages, overwritten pages and page bit 0 on word channels are all reached. Directed cases cover the reset state, counter values of all zeros and all ones, and the one-cycle output latency.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Window offset of the page register for a channel. Channels in the
  // upper controller sit eight bytes above their lower counterparts.
  function automatic logic [3:0] page_offset(input int unsigned ch);
    logic [3:0] lo;
    case (ch % 4)
      0:       lo = 4'h7;
      1:       lo = 4'h3;
      2:       lo = 4'h1;
      default: lo = 4'h2;
    endcase
    return (ch >= 4) ? (lo | 4'h8) : lo;
  endfunction

endpackage

// File: rtl/dpc_decode.sv
module dpc_decode #(
  parameter int CH_N  = 8,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  output logic [CH_N-1:0]  wr_sel,
  output logic             wr_hit
);

  for (genvar g = 0; g < CH_N; g++) begin : g_match
    assign wr_sel[g] = wr_en && (wr_off == OFF_W'(dpc_pkg::page_offset(g)));
  end

  assign wr_hit = |wr_sel;

  // R2 R3: one window offset may address at most one page register
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

  // R7: a hit can only come from a strobed write
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hit |-> wr_en);

endmodule

// File: rtl/dpc_page_file.sv
module dpc_page_file #(
  parameter int CH_N = 8,
  parameter int PG_W = 8,
  localparam int CH_W = $clog2(CH_N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_N-1:0] wr_sel,
  input  logic [PG_W-1:0] wr_data,
  input  logic [CH_W-1:0] rd_ch,
  output logic [PG_W-1:0] rd_page
);

  logic [PG_W-1:0]      pg_q [CH_N];
  logic [CH_N*PG_W-1:0] pg_flat;

  for (genvar g = 0; g < CH_N; g++) begin : g_page
    always_ff @(posedge clk) begin
      if (rst)            pg_q[g] <= '0;
      else if (wr_sel[g]) pg_q[g] <= wr_data;
    end
    assign pg_flat[g*PG_W +: PG_W] = pg_q[g];
  end

  assign rd_page = pg_q[rd_ch];

  // R7: without a decoded write, no page register changes
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel == '0) |=> $stable(pg_flat));

  // R1: the cycle after reset, every page register is clear
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pg_flat == '0));

endmodule

// File: rtl/dpc_compose.sv
module dpc_compose #(
  parameter int PG_W  = 8,
  parameter int CNT_W = 16,
  parameter int CH_W  = 3,
  localparam int OUT_W = PG_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  ch,
  input  logic [PG_W-1:0]  page,
  input  logic [CNT_W-1:0] cnt,
  output logic [OUT_W-1:0] addr_q,
  output logic             word_q
);

  logic             is_word;
  logic [OUT_W-1:0] addr_d;
  logic             primed_q;

  assign is_word = ch[CH_W-1];

  always_comb begin
    if (is_word) addr_d = {page[PG_W-1:1], cnt, 1'b0};
    else         addr_d = {page, cnt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      word_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      word_q   <= is_word;
      primed_q <= 1'b1;
    end
  end

  // R5: a word address is always even
  word_even_chk: assert property (@(posedge clk) disable iff (rst)
    word_q |-> (addr_q[0] == 1'b0));

  // R8: the width flag follows the channel seen one edge earlier
  word_flag_chk: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (word_q == $past(ch[CH_W-1])));

  // R4: a byte channel passes the counter through unshifted
  byte_low_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && !word_q) |-> (addr_q[CNT_W-1:0] == $past(cnt)));

  // R5: a word channel shifts the counter up by one place
  word_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && word_q) |-> (addr_q[CNT_W:1] == $past(cnt)));

endmodule

// File: rtl/dma_page_composer.sv
module dma_page_composer #(
  parameter int CH_N  = 8,
  parameter int PG_W  = 8,
  parameter int CNT_W = 16,
  parameter int OFF_W = 4,
  localparam int CH_W  = $clog2(CH_N),
  localparam int OUT_W = PG_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [PG_W-1:0]  wr_data,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [CNT_W-1:0] chan_addr,
  output logic [OUT_W-1:0] bus_addr,
  output logic             word_xfer
);

  logic [CH_N-1:0] wr_sel;
  logic            wr_hit;
  logic [PG_W-1:0] sel_page;

  dpc_decode #(.CH_N(CH_N), .OFF_W(OFF_W)) u_decode (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_off (wr_off),
    .wr_sel (wr_sel),
    .wr_hit (wr_hit)
  );

  dpc_page_file #(.CH_N(CH_N), .PG_W(PG_W)) u_pages (
    .clk     (clk),
    .rst     (rst),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_ch   (chan_sel),
    .rd_page (sel_page)
  );

  dpc_compose #(.PG_W(PG_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_compose (
    .clk    (clk),
    .rst    (rst),
    .ch     (chan_sel),
    .page   (sel_page),
    .cnt    (chan_addr),
    .addr_q (bus_addr),
    .word_q (word_xfer)
  );

  // R1: outputs are clear the cycle after reset
  out_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (bus_addr == '0 && !word_xfer));

  // R2 R3: a hit never happens without a strobe at the top
  hit_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !wr_hit);

endmodule

// File: tb/tb_dma_page_composer.sv
`timescale 1ns/1ps
module tb_dma_page_composer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_off = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  chan_sel = '0;
  logic [15:0] chan_addr = '0;
  logic [23:0] bus_addr;
  logic        word_xfer;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [8];
  bit done = 0;

  always #2 clk = ~clk;

  dma_page_composer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .chan_sel(chan_sel), .chan_addr(chan_addr),
    .bus_addr(bus_addr), .word_xfer(word_xfer)
  );

  function automatic int off_to_ch(input logic [3:0] off);
    case (off)
      4'h7: return 0;  4'h3: return 1;  4'h1: return 2;  4'h2: return 3;
      4'hF: return 4;  4'hB: return 5;  4'h9: return 6;  4'hA: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [3:0] ch_to_off(input int ch);
    case (ch)
      0: return 4'h7; 1: return 4'h3; 2: return 4'h1; 3: return 4'h2;
      4: return 4'hF; 5: return 4'hB; 6: return 4'h9; default: return 4'hA;
    endcase
  endfunction

  function automatic logic [23:0] exp_addr(input int ch, input logic [15:0] a);
    if (ch < 4) return {model[ch], a};
    return {model[ch][7:1], a, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (off_to_ch(off) >= 0) model[off_to_ch(off)] = d;
  endtask

  task automatic look(input string req, input int ch, input logic [15:0] a);
    @(negedge clk);
    chan_sel = 3'(ch); chan_addr = a;
    @(posedge clk); #1;
    chk(req, {8'h0, bus_addr}, {8'h0, exp_addr(ch, a)});
    chk("R8", {31'h0, word_xfer}, {31'h0, (ch >= 4)});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: outputs clear out of reset
    chk("R1", {8'h0, bus_addr}, 32'h0);
    chk("R1", {31'h0, word_xfer}, 32'h0);
    for (int c = 0; c < 8; c++) look("R1", c, 16'h0000);

    // R2 R4: byte channels through their offsets
    wr(4'h7, 8'hA5); look("R2", 0, 16'h1234);
    wr(4'h3, 8'h11); look("R2", 1, 16'hFFFF);
    wr(4'h1, 8'hFE); look("R4", 2, 16'h0000);
    wr(4'h2, 8'h80); look("R4", 3, 16'h8001);

    // R3 R5: word channels
    wr(4'hF, 8'h37); look("R3", 4, 16'h8001);
    wr(4'hB, 8'hFF); look("R5", 5, 16'hFFFF);
    wr(4'h9, 8'h02); look("R3", 6, 16'h0000);
    wr(4'hA, 8'h5A); look("R5", 7, 16'h7FFF);

    // R6: page bit 0 has no effect on a word channel
    wr(4'hF, 8'h36); look("R6", 4, 16'h8001);
    chk("R6", {8'h0, bus_addr}, 32'h00370002 & 32'h00FFFFFE);
    wr(4'hF, 8'h37); look("R6", 4, 16'h8001);
    chk("R6", {8'h0, bus_addr}, 32'h00370002 & 32'h00FFFFFE);

    // R7: unused offsets leave all pages unchanged
    foreach (model[k]) begin end
    wr(4'h0, 8'hFF); wr(4'h4, 8'hFF); wr(4'h5, 8'hFF); wr(4'h6, 8'hFF);
    wr(4'h8, 8'hFF); wr(4'hC, 8'hFF); wr(4'hD, 8'hFF); wr(4'hE, 8'hFF);
    for (int c = 0; c < 8; c++) look("R7", c, 16'h4321);

    // R9: output holds until the next edge, write lands on the second edge
    look("R9", 1, 16'h0101);
    @(negedge clk);
    chan_sel = 3'd0; chan_addr = 16'hBEEF;
    #1;
    chk("R9", {8'h0, bus_addr}, {8'h0, exp_addr(1, 16'h0101)});
    @(negedge clk);
    wr_en = 1'b1; wr_off = 4'h7; wr_data = 8'h3C;
    @(posedge clk); #1;
    chk("R9", {8'h0, bus_addr}, {8'h0, model[0], 16'hBEEF});
    @(negedge clk); wr_en = 1'b0; model[0] = 8'h3C;
    @(posedge clk); #1;
    chk("R9", {8'h0, bus_addr}, {8'h0, 8'h3C, 16'hBEEF});

    // R2 R3 R4 R5 R7: random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 1) == 0)
        wr(4'($urandom_range(0, 15)), 8'($urandom));
      else
        look(($urandom_range(0, 1) == 0) ? "R4" : "R5",
             int'($urandom_range(0, 7)), 16'($urandom));
    end
    for (int c = 0; c < 8; c++) begin
      wr(ch_to_off(c), 8'(c * 37 + 1));
      look(c < 4 ? "R2" : "R3", c, 16'(c * 4099));
    end

    done = 1;
    finish_run();
  end

endmodule